// File: doc/BRIEF.md
# Debug Link CRC-8 Framer

This block keeps a running 8-bit CRC over all traffic of one command on a half-duplex debug serial link. Bytes arriving from the host and bytes the target sends back are reported to it as single-cycle strobes. Both directions feed one shared checksum. A command-start pulse presets the checksum, and a command-end pulse closes the command. If appending is allowed at that point, the block offers the finished checksum byte to the transmit path. The offer stays up until the transmit path accepts it.

The checksum uses the generator x^8 + x^2 + x + 1. It is kept in an LSB-first (reflected) register that starts at all ones. The byte sent out is that register complemented. Appending is held back in three cases: for the first command after reset, while the link is not yet initialised, and while the software enable is clear. The appended byte itself is not reported back on the transmit strobe. Bit timing, baud generation and command decoding belong to the surrounding logic.

Top module: `dbg_crc8_framer`

## Requirements
- R1: Each folded byte is processed LSB first through the reflected form (0xE0) of the generator x^8 + x^2 + x + 1: the register XORs the byte, then 8 times shifts right and XORs 0xE0 when the bit shifted out is 1.
- R2: A `cmd_start` pulse presets the register to 0xFF before the strobes of that same cycle are folded, so bytes seen before the pulse have no effect on the next `crc_byte`.
- R3: `rx_valid` and `tx_valid` bytes fold into the same register; when both strobe in one cycle, the received byte is folded first.
- R4: `crc_byte` is the bitwise complement of the LSB-first register (the bit-reversed, inverted MSB-first value), so folding all command bytes followed by `crc_byte` into a fresh 0xFF register leaves 0xCF.
- R5: When `cmd_end` is high while `crc_en` and `link_init` are high and a previous command has ended since reset, `crc_req` is 1 in the following cycle.
- R6: The first command to end after reset never raises `crc_req`.
- R7: A command that ends while `link_init` is low does not raise `crc_req`.
- R8: A command that ends while `crc_en` is low does not raise `crc_req`.
- R9: `crc_req` holds with `crc_byte` stable until `crc_ack` is seen; it is 0 in the cycle after the acknowledge unless a new command ends in that cycle.
- R10: After reset, `crc_req` is 0 and `crc_byte` is 0x00.
- R11: Strobes that arrive in the same cycle as `cmd_end` are included in the appended checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Pulse at the first cycle of a command |
| cmd_end | input | 1 | Pulse at the last cycle of a command |
| crc_en | input | 1 | Software enable for appending the checksum |
| link_init | input | 1 | High once the debug link is initialised |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | input | 1 | Transmitted byte strobe |
| tx_data | input | 8 | Transmitted byte |
| crc_ack | input | 1 | Transmit path has taken the checksum byte |
| crc_req | output | 1 | Checksum byte waiting to be sent |
| crc_byte | output | 8 | Checksum byte to append |

## Verification
The hardest case to reach is a cycle where a receive strobe, a transmit strobe and a command boundary pulse all coincide. That cycle is the only place where fold order and the preset or capture point can be told apart from the ports. The stimulus drives such cycles on purpose. It pairs receive and transmit bytes whose order changes the result, places strobes on the `cmd_start` and `cmd_end` cycles, and folds unrelated bytes before a start. The final byte is checked against a bench model and by the 0xCF residue, which covers all 256 single-byte commands.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int unsigned CRC_W = 8;

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        logic vld;
        crc_t data;
    } strobe_t;

    typedef enum logic [1:0] {
        GATE_SEND   = 2'd0,
        GATE_FIRST  = 2'd1,
        GATE_UNINIT = 2'd2,
        GATE_OFF    = 2'd3
    } gate_e;

    // One byte through the reflected generator, LSB first.
    function automatic crc_t crc_fold(input crc_t state, input crc_t data, input crc_t poly_r);
        crc_t x;
        x = state ^ data;
        for (int i = 0; i < CRC_W; i++) begin
            x = x[0] ? ((x >> 1) ^ poly_r) : (x >> 1);
        end
        return x;
    endfunction

    function automatic crc_t fold_strobe(input crc_t state, input strobe_t s, input crc_t poly_r);
        return s.vld ? crc_fold(state, s.data, poly_r) : state;
    endfunction
endpackage

// File: rtl/dcf_accum.sv
module dcf_accum
    import dcf_pkg::*;
#(
    parameter crc_t POLY_R   = 8'hE0,
    parameter crc_t PRESET   = 8'hFF,
    parameter bit   RX_FIRST = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  strobe_t a_rx,
    input  strobe_t a_tx,
    output crc_t    state_q,
    output crc_t    next_o
);
    crc_t base;
    crc_t mid;
    crc_t fin;

    assign base = clear ? PRESET : state_q;

    generate
        if (RX_FIRST) begin : g_rx_first
            assign mid = fold_strobe(base, a_rx, POLY_R);
            assign fin = fold_strobe(mid, a_tx, POLY_R);
        end else begin : g_tx_first
            assign mid = fold_strobe(base, a_tx, POLY_R);
            assign fin = fold_strobe(mid, a_rx, POLY_R);
        end
    endgenerate

    assign next_o = fin;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PRESET;
        else     state_q <= fin;
    end
endmodule

// File: rtl/dcf_gate.sv
module dcf_gate
    import dcf_pkg::*;
(
    input  logic  first_done,
    input  logic  link_init,
    input  logic  crc_en,
    output gate_e gate
);
    always_comb begin
        if (!first_done)     gate = GATE_FIRST;
        else if (!link_init) gate = GATE_UNINIT;
        else if (!crc_en)    gate = GATE_OFF;
        else                 gate = GATE_SEND;
    end
endmodule

// File: rtl/dcf_sender.sv
module dcf_sender
    import dcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_end,
    input  gate_e gate,
    input  crc_t  crc_next,
    input  logic  ack,
    output logic  first_done,
    output logic  req,
    output crc_t  out_byte
);
    logic send_now;

    assign send_now = cmd_end && (gate == GATE_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_done <= 1'b0;
            req        <= 1'b0;
            out_byte   <= '0;
        end else begin
            if (cmd_end) first_done <= 1'b1;
            req <= send_now | (req & ~ack);
            if (send_now) out_byte <= ~crc_next;
        end
    end
endmodule

// File: rtl/dbg_crc8_framer.sv
module dbg_crc8_framer
    import dcf_pkg::*;
#(
    parameter crc_t POLY_R   = 8'hE0,
    parameter crc_t PRESET   = 8'hFF,
    parameter bit   RX_FIRST = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_start,
    input  logic       cmd_end,
    input  logic       crc_en,
    input  logic       link_init,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       crc_ack,
    output logic       crc_req,
    output logic [7:0] crc_byte
);
    strobe_t s_rx;
    strobe_t s_tx;
    crc_t    acc_state;
    crc_t    acc_next;
    gate_e   gate;
    logic    first_done;

    assign s_rx = '{vld: rx_valid, data: rx_data};
    assign s_tx = '{vld: tx_valid, data: tx_data};

    dcf_accum #(
        .POLY_R  (POLY_R),
        .PRESET  (PRESET),
        .RX_FIRST(RX_FIRST)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (cmd_start),
        .a_rx   (s_rx),
        .a_tx   (s_tx),
        .state_q(acc_state),
        .next_o (acc_next)
    );

    dcf_gate u_gate (
        .first_done(first_done),
        .link_init (link_init),
        .crc_en    (crc_en),
        .gate      (gate)
    );

    dcf_sender u_snd (
        .clk       (clk),
        .rst       (rst),
        .cmd_end   (cmd_end),
        .gate      (gate),
        .crc_next  (acc_next),
        .ack       (crc_ack),
        .first_done(first_done),
        .req       (crc_req),
        .out_byte  (crc_byte)
    );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_start,
    input logic       cmd_end,
    input logic       crc_en,
    input logic       link_init,
    input logic       rx_valid,
    input logic       tx_valid,
    input logic       crc_ack,
    input logic       crc_req,
    input logic [7:0] crc_byte,
    input logic [7:0] acc_state
);
    logic seen_end;

    always_ff @(posedge clk) begin
        if (rst) seen_end <= 1'b0;
        else if (cmd_end) seen_end <= 1'b1;
    end

    // R2
    p_preset_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !rx_valid && !tx_valid) |=> (acc_state == 8'hFF));

    // R2: with no strobes and no start, the register keeps its value
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cmd_start && !rx_valid && !tx_valid) |=> $stable(acc_state));

    // R5
    p_send_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && crc_en && link_init && seen_end) |=> crc_req);

    // R6
    p_first_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && !seen_end && (!crc_req || crc_ack)) |=> !crc_req);

    // R7
    p_uninit_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && !link_init && (!crc_req || crc_ack)) |=> !crc_req);

    // R8
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && !crc_en && (!crc_req || crc_ack)) |=> !crc_req);

    // R9
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (crc_req && !crc_ack && !cmd_end) |=> (crc_req && $stable(crc_byte)));

    // R9
    p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (crc_ack && !cmd_end) |=> !crc_req);
endmodule

bind dbg_crc8_framer dcf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_start(cmd_start),
    .cmd_end  (cmd_end),
    .crc_en   (crc_en),
    .link_init(link_init),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .crc_ack  (crc_ack),
    .crc_req  (crc_req),
    .crc_byte (crc_byte),
    .acc_state(acc_state)
);

// File: tb/sim_dbg_crc8_framer.sv
module sim_dbg_crc8_framer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_start = 1'b0;
    logic       cmd_end = 1'b0;
    logic       crc_en = 1'b1;
    logic       link_init = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       crc_ack = 1'b0;
    logic       crc_req;
    logic [7:0] crc_byte;

    int checks = 0;
    int errors = 0;
    logic [7:0] mcrc = 8'hFF;
    bit ended_once = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_crc8_framer u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_end(cmd_end),
        .crc_en(crc_en), .link_init(link_init),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .crc_ack(crc_ack), .crc_req(crc_req), .crc_byte(crc_byte)
    );

    // Arithmetic model: reflected x^8+x^2+x+1, LSB first
    function automatic logic [7:0] mfold(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ 8'hE0) : (x >> 1);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; model updated with the same rules as R2/R3
    task automatic put(input bit st, input bit rv, input logic [7:0] rd,
                       input bit tv, input logic [7:0] td, input bit en);
        cmd_start = st; cmd_end = en;
        rx_valid = rv; rx_data = rd; tx_valid = tv; tx_data = td;
        if (st) mcrc = 8'hFF;
        if (rv) mcrc = mfold(mcrc, rd);
        if (tv) mcrc = mfold(mcrc, td);
        @(negedge clk);
        cmd_start = 1'b0; cmd_end = 1'b0; rx_valid = 1'b0; tx_valid = 1'b0;
        if (en) ended_once = 1'b1;
    endtask

    task automatic do_ack();
        crc_ack = 1'b1;
        @(negedge clk);
        crc_ack = 1'b0;
        chk("R9 req cleared after ack", {7'd0, crc_req}, 8'h00);
    endtask

    // Checks an appended byte: value from model (R1) and residue (R4)
    task automatic chk_sent(input string tag);
        chk({tag, " R5 req"}, {7'd0, crc_req}, 8'h01);
        chk({tag, " R1 byte"}, crc_byte, ~mcrc);
        chk({tag, " R4 residue"}, mfold(mcrc, crc_byte), 8'hCF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset req", {7'd0, crc_req}, 8'h00);
        chk("R10 reset byte", crc_byte, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        // R6: first command, everything else permits sending
        put(1, 1, 8'h00, 0, 8'h00, 0);
        put(0, 0, 8'h00, 1, 8'h5A, 1);
        chk("R6 first command quiet", {7'd0, crc_req}, 8'h00);

        // R7: link not initialised
        link_init = 1'b0;
        put(1, 1, 8'h33, 0, 8'h00, 0);
        put(0, 0, 8'h00, 0, 8'h00, 1);
        chk("R7 uninit quiet", {7'd0, crc_req}, 8'h00);
        link_init = 1'b1;

        // R1/R4/R5: sweep every single-byte command
        for (int b = 0; b < 256; b++) begin
            put(1, 1, b[7:0], 0, 8'h00, 0);
            put(0, 0, 8'h00, 0, 8'h00, 1);
            chk_sent("sweep");
            do_ack();
        end

        // R3/R11: simultaneous strobes, bytes on the end cycle
        for (int k = 0; k < 16; k++) begin
            put(1, 1, 8'(k * 17), 1, 8'(8'hF0 ^ k), 0);
            put(0, 1, 8'(k + 8'h40), 0, 8'h00, 0);
            put(0, 0, 8'h00, 1, 8'(k * 3), 0);
            put(0, 1, 8'(8'hA5 ^ k), 1, 8'(k << 4), 1);
            chk_sent("R3 R11 mixed");
            do_ack();
        end

        // R3: order matters: rx first then tx, distinct from swapped order
        put(1, 1, 8'h12, 1, 8'h34, 1);
        chk_sent("R3 order");
        chk("R3 order not swapped", crc_byte == ~mfold(mfold(8'hFF, 8'h34), 8'h12) ? 8'h01 : 8'h00, 8'h00);
        do_ack();

        // R2: bytes before start, with and without a pending command
        put(0, 1, 8'hDE, 1, 8'hAD, 0);
        put(1, 0, 8'h00, 1, 8'h77, 0);
        put(0, 1, 8'h01, 0, 8'h00, 1);
        chk_sent("R2 preset");
        chk("R2 preset value", crc_byte, ~mfold(mfold(8'hFF, 8'h77), 8'h01));
        do_ack();

        // R9: hold without ack
        put(1, 0, 8'h00, 1, 8'hC3, 1);
        for (int w = 0; w < 6; w++) begin
            @(negedge clk);
            chk("R9 hold req", {7'd0, crc_req}, 8'h01);
            chk("R9 hold byte", crc_byte, ~mcrc);
        end
        do_ack();

        // R8: enable cleared
        crc_en = 1'b0;
        put(1, 1, 8'h99, 1, 8'h66, 1);
        chk("R8 disabled quiet", {7'd0, crc_req}, 8'h00);
        crc_en = 1'b1;

        // empty command after re-enable
        put(1, 0, 8'h00, 0, 8'h00, 1);
        chk_sent("R4 empty");
        chk("R4 empty value", crc_byte, 8'h00);
        do_ack();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule